// File: doc/BRIEF.md
# Debug Port Transaction Control Register

This block is one 16-bit software-visible control and status word. It starts a single read or write request on a debug-port transaction engine and reports how that request ended. Software first chooses the direction. It then sets a launch bit. The block sends the engine a one-cycle request strobe and a steady direction level. It then waits for the engine's completion pulse, which may carry an error flag. While a request is open, the block also watches two port-condition inputs, port suspended and port in reset. Either one ends the request at once as a hardware error.

The register is written through a plain write strobe that has two byte enables. It is read through a combinational read-data bus. The bus has no handshake and no back-pressure: every write is taken in the cycle it is strobed. Bit layout: bit 0 launch (go), bit 1 direction (1 = write, 0 = read), bit 2 error flag, bits 5:3 exception code, bit 6 in-use flag, bits 11:8 link identifier (reads 0), bit 12 done flag. Bits 7 and 15:13 are reserved and read 0. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 15:8.

Top module: `dbg_ctl_csr`

## Requirements
- R1: After reset the read data is 0x0000 and the request strobe is low.
- R2: Writing 1 to bit 0 while go is 0 sets go. In the next cycle the request strobe is high for exactly one cycle, and the direction output equals the bit 1 value from that same write.
- R3: An engine completion pulse with its error input low, taken while go is 1, clears go and sets done (bit 12) on the same clock edge. It also clears the error flag and sets the exception code to 000. A completion pulse while go is 0 changes nothing.
- R4: An engine completion with its error input high sets the error flag and the exception code 001. The error flag reads 1 exactly when the exception code is not 000.
- R5: If the port is suspended or in reset on the edge that would launch a request, no request strobe is issued. Go reads 0, done reads 1, the error flag reads 1 and the exception code is 010.
- R6: If the port becomes suspended or in reset while go is 1, the request ends on the next edge with go 0, done 1, error 1 and exception code 010. A later engine completion pulse is then ignored.
- R7: Writing 1 to bit 12 with byte enable 1 clears done, and writing 0 there has no effect. When hardware sets done on the same edge as a clear, done ends up 1.
- R8: Writing 0 to bit 0 has no effect on go. Writing 1 to bit 0 while go is already 1 issues no second strobe and changes no state.
- R9: While go is 1, writes to bit 1 are ignored and the direction output holds steady.
- R10: The link identifier bits 11:8 and the reserved bits 7 and 15:13 always read 0, even after writes of all ones.
- R11: The in-use bit 6 reads back the last value written to it and has no effect on requests.
- R12: A write changes bits 7:0 only when byte enable 0 is set, and bits 15:8 only when byte enable 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_be | input | 2 | Byte enables for the write |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Current register value |
| req_pulse | output | 1 | One-cycle request strobe to the engine |
| req_write | output | 1 | Request direction, 1 = write |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error qualifier, valid with eng_done |
| port_suspended | input | 1 | Port is suspended |
| port_in_reset | input | 1 | Port is in reset |

## Verification
A stuck or wrong go bit shows at the ports on the very next read. It appears as a missing or second request strobe, or as a direction change during an open request, one cycle after the launching write. A wrong completion state shows in the read word on the edge after the engine pulse or the port-condition change. There, done, error flag and exception code must all agree, and go must read 0. The sweep covers both directions with each of the six ways a request can end. For each one it checks the whole read word, so a corrupted neighbouring field is also caught.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int CSR_W    = 16;
  localparam int LANE_W   = 8;
  localparam int B_GO     = 0;
  localparam int B_DIR    = 1;
  localparam int B_ERR    = 2;
  localparam int B_EXC_LO = 3;
  localparam int EXC_W    = 3;
  localparam int B_INUSE  = 6;
  localparam int B_LINK_LO = 8;
  localparam int LINK_W   = 4;
  localparam int B_DONE   = 12;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE = 3'b000,
    EXC_XACT = 3'b001,
    EXC_PORT = 3'b010
  } exc_e;
endpackage

// File: rtl/dbg_csr_launch.sv
module dbg_csr_launch
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic go_wdata,
  input  logic dir_wdata,
  input  logic eng_done,
  input  logic eng_err,
  input  logic port_bad,
  output logic go_q,
  output logic dir_q,
  output logic req_pulse,
  output logic fin_valid,
  output exc_e fin_code
);
  logic start;
  logic abort_now;
  logic eng_fin;

  // a launch only counts when no request is open
  assign start     = ctl_wr && go_wdata && !go_q;
  assign abort_now = (start || go_q) && port_bad;
  assign eng_fin   = go_q && eng_done && !port_bad;
  assign fin_valid = abort_now || eng_fin;

  always_comb begin
    if (port_bad)     fin_code = EXC_PORT;
    else if (eng_err) fin_code = EXC_XACT;
    else              fin_code = EXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q      <= 1'b0;
      dir_q     <= 1'b0;
      req_pulse <= 1'b0;
    end else begin
      if (fin_valid)  go_q <= 1'b0;
      else if (start) go_q <= 1'b1;
      if (ctl_wr && !go_q) dir_q <= dir_wdata;
      req_pulse <= start && !port_bad;
    end
  end
endmodule

// File: rtl/dbg_csr_status.sv
module dbg_csr_status
  import dbg_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_valid,
  input  exc_e             fin_code,
  input  logic             done_clr,
  input  logic             inuse_wr,
  input  logic             inuse_wdata,
  output logic             done_q,
  output logic             err_q,
  output logic [EXC_W-1:0] exc_q,
  output logic             inuse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      exc_q   <= EXC_NONE;
      inuse_q <= 1'b0;
    end else begin
      // a completion by hardware takes priority over a software clear
      if (fin_valid)     done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (fin_valid) begin
        err_q <= (fin_code != EXC_NONE);
        exc_q <= fin_code;
      end
      if (inuse_wr) inuse_q <= inuse_wdata;
    end
  end
endmodule

// File: rtl/dbg_csr_readmux.sv
module dbg_csr_readmux
  import dbg_csr_pkg::*;
#(
  parameter logic [LINK_W-1:0] LINK_VALUE = '0
) (
  input  logic             go_q,
  input  logic             dir_q,
  input  logic             err_q,
  input  logic [EXC_W-1:0] exc_q,
  input  logic             inuse_q,
  input  logic             done_q,
  output logic [CSR_W-1:0] rdata
);
  always_comb begin
    rdata                       = '0;
    rdata[B_GO]                 = go_q;
    rdata[B_DIR]                = dir_q;
    rdata[B_ERR]                = err_q;
    rdata[B_EXC_LO +: EXC_W]    = exc_q;
    rdata[B_INUSE]              = inuse_q;
    rdata[B_LINK_LO +: LINK_W]  = LINK_VALUE;
    rdata[B_DONE]               = done_q;
  end
endmodule

// File: rtl/dbg_ctl_csr.sv
module dbg_ctl_csr
  import dbg_csr_pkg::*;
#(
  parameter logic [LINK_W-1:0] LINK_VALUE = '0,
  localparam int NBE = CSR_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [NBE-1:0]   csr_be,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             req_pulse,
  output logic             req_write,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             port_suspended,
  input  logic             port_in_reset
);
  logic [NBE-1:0] lane_wr;
  logic go_q, dir_q, fin_valid, done_q, err_q, inuse_q, port_bad;
  logic [EXC_W-1:0] exc_q;
  exc_e fin_code;

  for (genvar i = 0; i < NBE; i++) begin : g_lane
    assign lane_wr[i] = csr_we && csr_be[i];
  end

  assign port_bad  = port_suspended || port_in_reset;
  assign req_write = dir_q;

  dbg_csr_launch i_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (lane_wr[B_GO / LANE_W]),
    .go_wdata  (csr_wdata[B_GO]),
    .dir_wdata (csr_wdata[B_DIR]),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .port_bad  (port_bad),
    .go_q      (go_q),
    .dir_q     (dir_q),
    .req_pulse (req_pulse),
    .fin_valid (fin_valid),
    .fin_code  (fin_code)
  );

  dbg_csr_status i_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .fin_valid   (fin_valid),
    .fin_code    (fin_code),
    .done_clr    (lane_wr[B_DONE / LANE_W] && csr_wdata[B_DONE]),
    .inuse_wr    (lane_wr[B_INUSE / LANE_W]),
    .inuse_wdata (csr_wdata[B_INUSE]),
    .done_q      (done_q),
    .err_q       (err_q),
    .exc_q       (exc_q),
    .inuse_q     (inuse_q)
  );

  dbg_csr_readmux #(.LINK_VALUE(LINK_VALUE)) i_rmux (
    .go_q    (go_q),
    .dir_q   (dir_q),
    .err_q   (err_q),
    .exc_q   (exc_q),
    .inuse_q (inuse_q),
    .done_q  (done_q),
    .rdata   (csr_rdata)
  );
endmodule

// File: rtl/dbg_csr_chk.sv
module dbg_csr_chk
  import dbg_csr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CSR_W-1:0] csr_rdata,
  input logic             req_pulse,
  input logic             req_write,
  input logic             port_suspended,
  input logic             port_in_reset
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) req_pulse |=> !req_pulse); // R2
  AST_PULSE_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n) req_pulse |-> csr_rdata[B_GO]); // R2
  AST_GO_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) ($past(csr_rdata[B_GO]) && !csr_rdata[B_GO]) |-> csr_rdata[B_DONE]); // R3
  AST_EXC_MATCHES_ERR: assert property (@(posedge clk) disable iff (!rst_n) (csr_rdata[B_ERR] == (csr_rdata[B_EXC_LO +: EXC_W] != 3'b000)) && (csr_rdata[B_EXC_LO +: EXC_W] <= 3'b010)); // R4
  AST_PORT_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (csr_rdata[B_GO] && (port_suspended || port_in_reset)) |=> (!csr_rdata[B_GO] && csr_rdata[B_DONE] && csr_rdata[B_ERR] && csr_rdata[B_EXC_LO +: EXC_W] == 3'b010)); // R6
  AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(csr_rdata[B_GO]) |-> $stable(req_write)); // R9
endmodule

bind dbg_ctl_csr dbg_csr_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .csr_rdata      (csr_rdata),
  .req_pulse      (req_pulse),
  .req_write      (req_write),
  .port_suspended (port_suspended),
  .port_in_reset  (port_in_reset)
);

// File: tb/test_dbg_ctl_csr.sv
module test_dbg_ctl_csr;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, csr_we = 0, eng_done = 0, eng_err = 0;
  logic port_suspended = 0, port_in_reset = 0;
  logic [1:0] csr_be = 0;
  logic [15:0] csr_wdata = 0, csr_rdata;
  logic req_pulse, req_write;
  int n_chk = 0, n_fail = 0, pulse_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_ctl_csr i_dbg_ctl_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_be(csr_be),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_pulse(req_pulse),
    .req_write(req_write), .eng_done(eng_done), .eng_err(eng_err),
    .port_suspended(port_suspended), .port_in_reset(port_in_reset)
  );

  always @(negedge clk) if (req_pulse) pulse_cnt++;

  function automatic logic [15:0] word(logic done, logic inuse, logic [2:0] exc,
                                       logic err, logic dir, logic go);
    return {3'b0, done, 4'b0, 1'b0, inuse, exc, err, dir, go};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d);
    @(negedge clk); csr_we = 1; csr_be = be; csr_wdata = d;
    @(negedge clk); csr_we = 0; csr_be = 0; csr_wdata = 0;
  endtask

  task automatic eng_pulse(logic e);
    @(negedge clk); eng_done = 1; eng_err = e;
    @(negedge clk); eng_done = 0; eng_err = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", csr_rdata, 16'h0000);
    chk("R1 reset strobe", req_pulse, 0);
    rst_n = 1;
    @(negedge clk);

    // byte lanes, reserved and link bits, in-use
    wr(2'b11, 16'hFFFE);
    chk("R10 R11 all-ones write", csr_rdata, word(0,1,0,0,1,0));
    wr(2'b10, 16'hFFFF);
    chk("R12 lane1 only", csr_rdata, word(0,1,0,0,1,0));
    wr(2'b00, 16'h0000);
    chk("R12 no lanes", csr_rdata, word(0,1,0,0,1,0));
    wr(2'b01, 16'h0000);
    chk("R12 R11 lane0 clear", csr_rdata, word(0,0,0,0,0,0));
    p0 = pulse_cnt;
    wr(2'b01, 16'h0040);
    @(negedge clk);
    chk("R11 in-use no launch", pulse_cnt, p0);
    chk("R11 in-use set", csr_rdata, word(0,1,0,0,0,0));
    wr(2'b01, 16'h0000);

    // idle completion ignored
    eng_pulse(1);
    chk("R3 idle completion ignored", csr_rdata, word(0,0,0,0,0,0));

    // sweep: direction x ending
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 6; m++) begin
        logic [2:0] ex;
        p0 = pulse_cnt;
        if (m == 2) begin @(negedge clk); port_suspended = 1; end
        if (m == 3) begin @(negedge clk); port_in_reset = 1; end
        wr(2'b01, 16'(d*2 + 1));
        @(negedge clk);
        if (m >= 2 && m <= 3) begin
          chk("R5 launch on bad port", csr_rdata, word(1,0,3'b010,1,d[0],0));
          chk("R5 no strobe", pulse_cnt, p0);
          port_suspended = 0; port_in_reset = 0;
        end else begin
          chk("R2 go set", csr_rdata, word(0,0,csr_rdata[5:3],csr_rdata[2],d[0],1));
          chk("R2 one strobe", pulse_cnt, p0 + 1);
          chk("R2 direction", req_write, d);
          if (m <= 1) begin
            eng_pulse(m[0]);
            ex = (m == 1) ? 3'b001 : 3'b000;
            chk(m == 1 ? "R4 transaction error" : "R3 clean completion",
                csr_rdata, word(1,0,ex,m[0],d[0],0));
          end else begin
            if (m == 4) port_suspended = 1; else port_in_reset = 1;
            @(negedge clk);
            chk("R6 abort while open", csr_rdata, word(1,0,3'b010,1,d[0],0));
            port_suspended = 0; port_in_reset = 0;
            eng_pulse(0);
            chk("R6 late completion ignored", csr_rdata, word(1,0,3'b010,1,d[0],0));
          end
        end
        wr(2'b10, 16'h1000);
        chk("R7 done cleared", csr_rdata[12], 0);
      end
    end

    // done write of 0, hardware set wins
    wr(2'b01, 16'h0001);
    eng_pulse(0);
    wr(2'b10, 16'h0000);
    chk("R7 zero write keeps done", csr_rdata, word(1,0,0,0,0,0));
    wr(2'b11, 16'h1003);
    @(negedge clk);
    csr_we = 1; csr_be = 2'b10; csr_wdata = 16'h1000; eng_done = 1;
    @(negedge clk);
    csr_we = 0; csr_be = 0; csr_wdata = 0; eng_done = 0;
    chk("R7 hardware set beats clear", csr_rdata, word(1,0,0,0,1,0));
    wr(2'b10, 16'h1000);

    // go rewrite and direction freeze
    p0 = pulse_cnt;
    wr(2'b01, 16'h0003);
    @(negedge clk);
    wr(2'b01, 16'h0001);
    @(negedge clk);
    chk("R8 no second strobe", pulse_cnt, p0 + 1);
    chk("R9 direction held", csr_rdata, word(0,0,0,0,1,1));
    chk("R9 direction output", req_write, 1);
    wr(2'b01, 16'h0000);
    chk("R8 zero write keeps go", csr_rdata, word(0,0,0,0,1,1));
    eng_pulse(0);
    chk("R3 completion after rewrites", csr_rdata, word(1,0,0,0,1,0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule